// File: doc/BRIEF.md
# Display Controller Power-State Sequencer

This block walks a mirror-array display controller through bring-up and shutdown. It watches a supply power-good flag, a reference-clock-valid flag, a projector-enable level and an active-low fast-park request. From these it drives the controller's active-low reset, a host-ready line and an I2C-access enable. It also issues the two parking commands, normal and fast, and a supply-hold request that keeps the rails up while an urgent park runs.

The sequencer releases the controller from reset only when four conditions hold at once: the supplies are good, the reference clock has been valid long enough, the enable is high and no fast park is pending. Releasing reset starts an initialization phase, and an input pulse ends it. If that pulse does not come in time, a timeout raises a sticky error flag and reset is asserted again.

There are two ways to shut down. Dropping the enable starts an orderly park. A fast-park request is urgent and takes over from an orderly park that is already running. The controller goes back into reset only when the park is done and, on the fast path, when a minimum supply-hold time has also run out. The enable and fast-park inputs are asynchronous, so each passes through a two-flop synchronizer before the state machine uses it. Every duration is a parameter counted in clock cycles. All pins are plain control levels, so the block has no valid/ready stream interface and no back-pressure rules.

Top module: `dpc_power_seq`

## Requirements
- R1: `ctrl_rst_n_o` stays low while `pwr_good_i` is low, and stays low in every cycle before the release conditions are met. After reset the outputs are `ctrl_rst_n_o`=0, `host_rdy_o`=1 and `i2c_en_o`=0.
- R2: Reset is released only after `refclk_ok_i` has been sampled high for CLK_STABLE_CYC consecutive cycles while power is good. A low sample restarts the count, and the release happens on the CLK_STABLE_CYC-th consecutive high sample.
- R3: Reset is not released while the synchronized enable is low or the synchronized fast-park request is active (low), however long the clock has been stable.
- R4: While initialization runs, `host_rdy_o` is 0. One cycle after `init_done_i` is sampled high, `host_rdy_o` is 1 and stays 1.
- R5: If `init_done_i` has not been seen after INIT_TMO_CYC cycles of initialization, reset is reasserted and `init_err_o` goes to 1. The flag stays at 1 until `rst_n` is asserted.
- R6: `i2c_en_o` is 1 only when initialization has finished and the enable is still high. It goes to 0 in the same cycle that the sequencer acts on a low enable.
- R7: A low enable in the ready state raises `park_req_o`. Reset is reasserted one cycle after `park_done_i` is sampled high, and not before.
- R8: A low fast-park request during initialization, ready or normal park raises `fpark_req_o` and `supply_hold_o` and clears `park_req_o`.
- R9: `supply_hold_o` stays high for at least HOLD_CYC cycles. Reset is reasserted only once that time has elapsed and `park_done_i` is high. With `park_done_i` already high, the hold lasts exactly HOLD_CYC cycles.
- R10: Whenever `ctrl_rst_n_o` is 0, `host_rdy_o` is 1, its released level.
- R11: After a shutdown the sequencer ignores the enable and stays in reset until `pwr_good_i` is sampled low. It then starts again from the off state.
- R12: A change on `proj_en_i` or `fast_park_n_i` affects the outputs on the third rising clock edge after the change: two synchronizer stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset of the sequencer itself |
| pwr_good_i | input | 1 | All supplies above their valid threshold |
| refclk_ok_i | input | 1 | Reference clock reported stable |
| proj_en_i | input | 1 | Projector enable level (asynchronous) |
| fast_park_n_i | input | 1 | Active-low urgent park request (asynchronous) |
| init_done_i | input | 1 | Pulse: controller initialization finished |
| park_done_i | input | 1 | Mirror parking finished |
| ctrl_rst_n_o | output | 1 | Active-low controller reset |
| host_rdy_o | output | 1 | Host ready level; high when ready or while in reset |
| i2c_en_o | output | 1 | Host I2C traffic permitted |
| park_req_o | output | 1 | Normal park command |
| fpark_req_o | output | 1 | Fast park command |
| supply_hold_o | output | 1 | Keep supplies and reference clock valid |
| init_err_o | output | 1 | Sticky initialization-timeout flag |

## Verification
The bench builds the block with CLK_STABLE_CYC=8, INIT_TMO_CYC=20 and HOLD_CYC=12 instead of the long defaults. With these values a clock dropout and restart, a full initialization timeout and a complete minimum supply hold each take only a few dozen cycles. Several power cycles therefore fit into one short run: an orderly park, a fast park from the ready state, a fast park that takes over a running normal park, and a timeout. A behavioural model with its own synchronizer delay line is compared against every output on every clock.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_WAIT_CLK  = 3'd1,
    ST_INIT      = 3'd2,
    ST_ACTIVE    = 3'd3,
    ST_PARK      = 3'd4,
    ST_FAST_PARK = 3'd5,
    ST_SHUTDOWN  = 3'd6
  } pseq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pseq_sync.sv
// Multi-stage synchronizer bank for asynchronous level inputs.
module pseq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= async_i;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pseq_cycle_timer.sv
// Saturating cycle counter with synchronous clear.
module pseq_cycle_timer #(
  parameter int WIDTH = 8,
  parameter int LIMIT = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] LIM = WIDTH'(LIMIT);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (en_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R9: the timer advances by one whenever it runs and is below its limit
  p_timer_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && en_i && cnt_q != LIM) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dpc_power_seq.sv
module dpc_power_seq
  import pseq_pkg::*;
#(
  parameter int CLK_STABLE_CYC = 2000,
  parameter int INIT_TMO_CYC   = 100000,
  parameter int HOLD_CYC       = 6400,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  input  logic refclk_ok_i,
  input  logic proj_en_i,
  input  logic fast_park_n_i,
  input  logic init_done_i,
  input  logic park_done_i,
  output logic ctrl_rst_n_o,
  output logic host_rdy_o,
  output logic i2c_en_o,
  output logic park_req_o,
  output logic fpark_req_o,
  output logic supply_hold_o,
  output logic init_err_o
);
  localparam int CNT_MAX = max3(CLK_STABLE_CYC, INIT_TMO_CYC, HOLD_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CLK_M1  = CNT_W'(CLK_STABLE_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_M1  = CNT_W'(INIT_TMO_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_M1 = CNT_W'(HOLD_CYC - 1);

  pseq_state_e      state_q, state_d;
  logic [1:0]       sync_vec;
  logic             en_s, fpn_s;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             err_set, err_q;

  // Input synchronization: bit 1 enable, bit 0 fast-park request (active low)
  pseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({proj_en_i, fast_park_n_i}),
    .sync_o  (sync_vec)
  );
  assign en_s  = sync_vec[1];
  assign fpn_s = sync_vec[0];

  // Shared phase timer: restarted on each state change and on clock dropout
  assign cnt_clr = (state_d != state_q) || (state_q == ST_WAIT_CLK && !refclk_ok_i);

  pseq_cycle_timer #(.WIDTH(CNT_W), .LIMIT(CNT_MAX)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .en_i  (1'b1),
    .cnt_o (cnt)
  );

  always_comb begin
    state_d = state_q;
    err_set = 1'b0;
    unique case (state_q)
      ST_OFF: if (pwr_good_i) state_d = ST_WAIT_CLK;
      ST_WAIT_CLK: begin
        if (!pwr_good_i) state_d = ST_OFF;
        else if (refclk_ok_i && cnt >= CLK_M1 && en_s && fpn_s) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (!fpn_s) state_d = ST_FAST_PARK;
        else if (init_done_i) state_d = ST_ACTIVE;
        else if (cnt >= TMO_M1) begin
          state_d = ST_SHUTDOWN;
          err_set = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (!fpn_s) state_d = ST_FAST_PARK;
        else if (!en_s) state_d = ST_PARK;
      end
      ST_PARK: begin
        if (!fpn_s) state_d = ST_FAST_PARK;
        else if (park_done_i) state_d = ST_SHUTDOWN;
      end
      ST_FAST_PARK: if (park_done_i && cnt >= HOLD_M1) state_d = ST_SHUTDOWN;
      ST_SHUTDOWN:  if (!pwr_good_i) state_d = ST_OFF;
      default:      state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign ctrl_rst_n_o  = (state_q == ST_INIT) || (state_q == ST_ACTIVE) ||
                         (state_q == ST_PARK) || (state_q == ST_FAST_PARK);
  assign host_rdy_o    = (state_q != ST_INIT);
  assign i2c_en_o      = (state_q == ST_ACTIVE);
  assign park_req_o    = (state_q == ST_PARK);
  assign fpark_req_o   = (state_q == ST_FAST_PARK);
  assign supply_hold_o = (state_q == ST_FAST_PARK);
  assign init_err_o    = err_q;

  // R10: ready line sits at its released level whenever reset is applied
  p_rdy_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rst_n_o |-> host_rdy_o);
  // R6: bus access only with reset released and ready shown
  p_i2c_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_en_o |-> (host_rdy_o && ctrl_rst_n_o));
  // R1: release needs good power and a valid clock in the deciding cycle
  p_release_power_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_n_o) |-> ($past(pwr_good_i) && $past(refclk_ok_i)));
  // R3: release needs the synchronized enable high and no fast park pending
  p_release_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_n_o) |-> ($past(en_s) && $past(fpn_s)));
  // R7: a normal park ends only in reset or in a takeover by fast park
  p_park_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(park_req_o) |-> (fpark_req_o || !ctrl_rst_n_o));
  // R9: the supply hold ends only after park completion, and reset follows
  p_hold_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_hold_o) |-> ($past(park_done_i) && !ctrl_rst_n_o));
  // R11: shutdown is left only after power-good is seen low
  p_shutdown_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_SHUTDOWN && state_q != ST_SHUTDOWN) |-> !$past(pwr_good_i));
  // R5: the timeout flag is sticky
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_err_o |=> init_err_o);
endmodule

// File: tb/dpc_power_seq_tb.sv
module dpc_power_seq_tb_top;
  localparam int CS   = 8;
  localparam int TMO  = 20;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good_i = 0, refclk_ok_i = 0, proj_en_i = 0, fast_park_n_i = 0;
  logic init_done_i = 0, park_done_i = 0;
  logic ctrl_rst_n_o, host_rdy_o, i2c_en_o, park_req_o, fpark_req_o, supply_hold_o, init_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dpc_power_seq #(.CLK_STABLE_CYC(CS), .INIT_TMO_CYC(TMO), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i), .refclk_ok_i(refclk_ok_i),
    .proj_en_i(proj_en_i), .fast_park_n_i(fast_park_n_i), .init_done_i(init_done_i),
    .park_done_i(park_done_i), .ctrl_rst_n_o(ctrl_rst_n_o), .host_rdy_o(host_rdy_o),
    .i2c_en_o(i2c_en_o), .park_req_o(park_req_o), .fpark_req_o(fpark_req_o),
    .supply_hold_o(supply_hold_o), .init_err_o(init_err_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  string m_st = "OFF";
  int    m_cnt = 0;
  bit    m_en1 = 0, m_en2 = 0, m_fp1 = 0, m_fp2 = 0, m_err = 0;

  always @(posedge clk) begin
    string nx;
    if (!rst_n) begin
      m_st = "OFF"; m_cnt = 0; m_err = 0;
      m_en1 = 0; m_en2 = 0; m_fp1 = 0; m_fp2 = 0;
    end else begin
      nx = m_st;
      case (m_st)
        "OFF":  if (pwr_good_i) nx = "WAIT";
        "WAIT": if (!pwr_good_i) nx = "OFF";
                else if (refclk_ok_i && m_cnt + 1 >= CS && m_en2 && m_fp2) nx = "INIT";
        "INIT": if (!m_fp2) nx = "FAST";
                else if (init_done_i) nx = "ACT";
                else if (m_cnt + 1 >= TMO) begin nx = "SD"; m_err = 1; end
        "ACT":  if (!m_fp2) nx = "FAST"; else if (!m_en2) nx = "PARK";
        "PARK": if (!m_fp2) nx = "FAST"; else if (park_done_i) nx = "SD";
        "FAST": if (park_done_i && m_cnt + 1 >= HOLD) nx = "SD";
        "SD":   if (!pwr_good_i) nx = "OFF";
        default: nx = "OFF";
      endcase
      if (nx != m_st || (m_st == "WAIT" && !refclk_ok_i)) m_cnt = 0;
      else m_cnt++;
      m_st = nx;
      m_en2 = m_en1; m_en1 = proj_en_i;
      m_fp2 = m_fp1; m_fp1 = fast_park_n_i;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit live;
      live = (m_st == "INIT" || m_st == "ACT" || m_st == "PARK" || m_st == "FAST");
      chk("R1", "model ctrl_rst_n_o", int'(ctrl_rst_n_o), int'(live));
      chk("R4", "model host_rdy_o", int'(host_rdy_o), int'(m_st != "INIT"));
      chk("R6", "model i2c_en_o", int'(i2c_en_o), int'(m_st == "ACT"));
      chk("R7", "model park_req_o", int'(park_req_o), int'(m_st == "PARK"));
      chk("R8", "model fpark_req_o", int'(fpark_req_o), int'(m_st == "FAST"));
      chk("R9", "model supply_hold_o", int'(supply_hold_o), int'(m_st == "FAST"));
      chk("R5", "model init_err_o", int'(init_err_o), int'(m_err));
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements: actual=hung expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 100 && ctrl_rst_n_o !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic init_pulse();
    init_done_i = 1; tick(1); init_done_i = 0;
  endtask

  task automatic power_cycle();
    pwr_good_i = 0; tick(2); pwr_good_i = 1;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    tick(4);
    chk("R1", "reset ctrl_rst_n_o", int'(ctrl_rst_n_o), 0);
    chk("R10", "reset host_rdy_o", int'(host_rdy_o), 1);
    chk("R6", "reset i2c_en_o", int'(i2c_en_o), 0);
    rst_n = 1;

    // R1: no power, everything else ready
    refclk_ok_i = 1; proj_en_i = 1; fast_park_n_i = 1;
    tick(30);
    chk("R1", "held without power", int'(ctrl_rst_n_o), 0);

    // R2: clock dropout restarts the stability count
    pwr_good_i = 1; tick(5);
    refclk_ok_i = 0; tick(1); refclk_ok_i = 1;
    tick(CS - 1);
    chk("R2", "one cycle short of stable time", int'(ctrl_rst_n_o), 0);
    tick(1);
    chk("R2", "released at stable time", int'(ctrl_rst_n_o), 1);
    chk("R4", "ready low during init", int'(host_rdy_o), 0);
    init_pulse();
    chk("R4", "ready after init done", int'(host_rdy_o), 1);
    chk("R6", "i2c enabled when ready", int'(i2c_en_o), 1);

    // R12, R6, R7: normal park
    proj_en_i = 0; tick(2);
    chk("R12", "enable drop not yet visible", int'(i2c_en_o), 1);
    tick(1);
    chk("R12", "enable drop visible third edge", int'(i2c_en_o), 0);
    chk("R7", "park requested", int'(park_req_o), 1);
    tick(10);
    chk("R7", "reset held while parking", int'(ctrl_rst_n_o), 1);
    park_done_i = 1; tick(1);
    chk("R7", "reset after park done", int'(ctrl_rst_n_o), 0);
    chk("R10", "ready released in reset", int'(host_rdy_o), 1);
    park_done_i = 0;

    // R11: enable has no effect in shutdown
    proj_en_i = 1; tick(20);
    chk("R11", "shutdown holds reset", int'(ctrl_rst_n_o), 0);

    // R3: release gated by enable and fast-park request
    proj_en_i = 0; power_cycle(); tick(40);
    chk("R3", "held with enable low", int'(ctrl_rst_n_o), 0);
    proj_en_i = 1; fast_park_n_i = 0; tick(40);
    chk("R3", "held with fast park pending", int'(ctrl_rst_n_o), 0);
    fast_park_n_i = 1; tick(3);
    chk("R3", "released once both high", int'(ctrl_rst_n_o), 1);
    init_pulse();

    // R8, R9: fast park from ready with park already done
    begin
      int n = 0;
      park_done_i = 1; fast_park_n_i = 0;
      for (int i = 0; i < 10 && supply_hold_o !== 1'b1; i++) tick(1);
      chk("R8", "fast park raised", int'(fpark_req_o), 1);
      for (int i = 0; i < 100 && supply_hold_o === 1'b1; i++) begin n++; tick(1); end
      chk("R9", "hold length", n, HOLD);
      chk("R9", "reset after hold", int'(ctrl_rst_n_o), 0);
      park_done_i = 0;
    end

    // R8, R9: fast park takes over a normal park
    fast_park_n_i = 1; power_cycle(); wait_release(); init_pulse();
    proj_en_i = 0; tick(3);
    chk("R7", "normal park running", int'(park_req_o), 1);
    fast_park_n_i = 0; tick(3);
    chk("R8", "fast park takes over", int'(fpark_req_o), 1);
    chk("R8", "normal park cleared", int'(park_req_o), 0);
    tick(HOLD + 5);
    chk("R9", "reset waits for park done", int'(ctrl_rst_n_o), 1);
    chk("R9", "hold kept while waiting", int'(supply_hold_o), 1);
    park_done_i = 1; tick(1);
    chk("R9", "reset after park done", int'(ctrl_rst_n_o), 0);
    park_done_i = 0;

    // R5: initialization timeout
    fast_park_n_i = 1; proj_en_i = 1; power_cycle(); wait_release();
    tick(TMO - 1);
    chk("R5", "no error before timeout", int'(init_err_o), 0);
    tick(1);
    chk("R5", "error at timeout", int'(init_err_o), 1);
    chk("R5", "reset at timeout", int'(ctrl_rst_n_o), 0);
    tick(5);
    chk("R5", "error sticky", int'(init_err_o), 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule